// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

This block is a register-mapped timer with a parameterised number of independent channels. Each channel holds a 64-bit interval and a 64-bit down-counter. Both are seen on a 32-bit bus as a low word and a high word. The counter decrements on prescaled ticks of the timer clock, and each prescaler setting divides by a power of two. When a channel's count is found at zero, the channel raises a pending flag. A channel in repeating mode then reloads its interval and keeps counting. A channel in single-shot mode instead drops its own enable and parks at zero.

The pending flags are gathered in one status word and are cleared by writing ones. The flags are ANDed with a per-channel mask to form a single interrupt line. A self-clearing load request copies the interval into the counter. With an all-ones interval, the low count word serves as a free-running timebase, and software inverts it to get a rising value.

When the enable is switched off, the counter does not stop at once. It keeps counting for a short settling window, which models a clock-domain crossing. Software must allow for this window.

Top module: `evt_timer_top`

## Requirements
- R1: After reset every mapped register reads 0 and `irq` is low.
- R2: Offset 0x00 holds the interrupt mask, one bit per channel with bit n for channel n. Offset 0x04 holds the pending flags; writing 1 to bit n clears flag n, and writing 0 leaves it. `irq` is high exactly when some flag and its mask bit are both 1.
- R3: Channel n occupies five words: control at 0x20*n+0x10, interval low/high at +0x14/+0x18, count low/high at +0x1C/+0x20. The interval words read back what was written, and each channel's words are separate from the other channels' words.
- R4: Control bit 0 is enable, bit 1 is a load request, bits 6:4 are the prescale code and bit 7 selects single-shot (1) or repeating (0). A load request copies the full 64-bit interval into the counter on the next prescaled tick, even when the channel is disabled. After that tick, bit 1 reads 0.
- R5: A running channel with prescale code 0 decrements its count by one every clock, so the bitwise inverse of the low count word rises by k over k clocks.
- R6: On a tick that finds the count at zero, the channel sets its pending flag. In repeating mode it reloads the interval, so flags are (I+1)*2^p clocks apart for interval I and prescale code p.
- R7: Prescale code p makes one tick every 2^p clocks, from divide-by-1 at code 0 up to divide-by-128 at code 7.
- R8: In single-shot mode, the expiry sets the flag once, clears control bit 0 and leaves the count at 0. No further flag follows.
- R9: After the edge that writes enable = 0, with prescale code 0, the count still decrements on that edge and on the next 2 edges (SYNC_LAT = 2). It then holds, so it ends 3 below the value read just before the write.
- R10: Reads of unmapped offsets (for example 0x08, 0x0C, or a channel slot at or beyond NUM_CH) return 0, and writes to them change no register.
- R11: A pending flag stays set until it is cleared and can be read whatever its mask bit. A masked flag does not drive `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from bus_addr |
| irq | output | 1 | Shared interrupt, OR of masked pending flags |

## Verification
The counting path is driven in three ways. The first is an all-ones interval that runs freely, which shows the per-clock decrement and the inverted rising value. The second is short repeating intervals at prescale codes 0, 2 and 7; the measured gap between flags separates errors in the interval term (I+1) from errors in the divider term 2^p. The third is a single-shot run, which shows whether the block stops itself or refires. A disable on a free-running channel checks the exact length of the settling window. A load request on a disabled channel checks that the counter is loaded without starting. Mask and status writes with the wrong bit and with the right bit separate write-one-to-clear from overwrite behaviour.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic [2:0] {
    FLD_NONE,
    FLD_IEN,
    FLD_IST,
    FLD_CTL,
    FLD_IVL_LO,
    FLD_IVL_HI,
    FLD_CNT_LO,
    FLD_CNT_HI
  } fld_e;

  localparam int OFS_IEN    = 0;
  localparam int OFS_IST    = 4;
  localparam int CH_BASE    = 16;
  localparam int CH_SHIFT   = 5;   // 0x20 stride
  localparam int REL_CTL    = 0;
  localparam int REL_IVL_LO = 4;
  localparam int REL_IVL_HI = 8;
  localparam int REL_CNT_LO = 12;
  localparam int REL_CNT_HI = 16;

  localparam int CTL_EN  = 0;
  localparam int CTL_RLD = 1;
  localparam int CTL_PRE = 4;
  localparam int CTL_OSH = 7;

endpackage

// File: rtl/evt_timer_dec.sv
module evt_timer_dec
  import evt_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int CH_IW  = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output fld_e              fld,
  output logic [CH_IW-1:0]  ch
);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] slot;

  always_comb begin
    fld  = FLD_NONE;
    ch   = '0;
    off  = addr - ADDR_W'(CH_BASE);
    slot = off >> CH_SHIFT;
    if (addr == ADDR_W'(OFS_IEN)) begin
      fld = FLD_IEN;
    end else if (addr == ADDR_W'(OFS_IST)) begin
      fld = FLD_IST;
    end else if ((addr >= ADDR_W'(CH_BASE)) && (slot < ADDR_W'(NUM_CH))) begin
      ch = CH_IW'(slot);
      case (off[CH_SHIFT-1:0])
        5'(REL_CTL):    fld = FLD_CTL;
        5'(REL_IVL_LO): fld = FLD_IVL_LO;
        5'(REL_IVL_HI): fld = FLD_IVL_HI;
        5'(REL_CNT_LO): fld = FLD_CNT_LO;
        5'(REL_CNT_HI): fld = FLD_CNT_HI;
        default:        fld = FLD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/evt_timer_presc.sv
module evt_timer_presc #(
  parameter int NUM_CH = 2,
  parameter int PRE_W  = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CH-1:0][PRE_W-1:0] presc,
  output logic [NUM_CH-1:0]            tick
);

  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_n;

  always_comb div_n = div_q + DIV_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_n;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_tick
    logic [DIV_W-1:0] mask;
    always_comb begin
      mask    = ~({DIV_W{1'b1}} << presc[n]);
      tick[n] = ((div_q & mask) == mask);
    end
  end

endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
  import evt_timer_pkg::*;
#(
  parameter int DW       = 32,
  parameter int PRE_W    = 3,
  parameter int SYNC_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             ivl_lo_we,
  input  logic             ivl_hi_we,
  input  logic [DW-1:0]    wdata,
  input  logic             tick,
  output logic [DW-1:0]    ctl_rd,
  output logic [PRE_W-1:0] presc,
  output logic [2*DW-1:0]  ivl_rd,
  output logic [2*DW-1:0]  cnt_rd,
  output logic             en_o,
  output logic             osh_o,
  output logic             rld_o,
  output logic             expire
);

  localparam int CW = 2 * DW;

  logic                en_q,   en_n;
  logic                osh_q,  osh_n;
  logic                rld_q,  rld_n;
  logic [PRE_W-1:0]    pre_q,  pre_n;
  logic [CW-1:0]       ivl_q,  ivl_n;
  logic [CW-1:0]       cnt_q,  cnt_n;
  logic [SYNC_LAT-1:0] pipe_q, pipe_n;
  logic                run;
  logic                fire;

  always_comb begin
    run    = pipe_q[SYNC_LAT-1];
    fire   = tick && !rld_q && run && (cnt_q == '0);
    en_n   = en_q;
    osh_n  = osh_q;
    rld_n  = rld_q;
    pre_n  = pre_q;
    ivl_n  = ivl_q;
    cnt_n  = cnt_q;
    pipe_n = SYNC_LAT'({pipe_q, en_q});

    if (tick) begin
      if (rld_q) begin
        cnt_n = ivl_q;
        rld_n = 1'b0;
      end else if (run) begin
        if (cnt_q == '0) begin
          if (osh_q) begin
            cnt_n  = '0;
            en_n   = 1'b0;
            pipe_n = '0;
          end else begin
            cnt_n = ivl_q;
          end
        end else begin
          cnt_n = cnt_q - CW'(1);
        end
      end
    end

    if (ivl_lo_we) ivl_n[DW-1:0]  = wdata;
    if (ivl_hi_we) ivl_n[CW-1:DW] = wdata;

    if (ctl_we) begin
      en_n  = wdata[CTL_EN];
      osh_n = wdata[CTL_OSH];
      pre_n = wdata[CTL_PRE +: PRE_W];
      if (wdata[CTL_RLD]) rld_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      osh_q  <= 1'b0;
      rld_q  <= 1'b0;
      pre_q  <= '0;
      ivl_q  <= '0;
      cnt_q  <= '0;
      pipe_q <= '0;
    end else begin
      en_q   <= en_n;
      osh_q  <= osh_n;
      rld_q  <= rld_n;
      pre_q  <= pre_n;
      ivl_q  <= ivl_n;
      cnt_q  <= cnt_n;
      pipe_q <= pipe_n;
    end
  end

  always_comb begin
    ctl_rd                    = '0;
    ctl_rd[CTL_EN]            = en_q;
    ctl_rd[CTL_RLD]           = rld_q;
    ctl_rd[CTL_PRE +: PRE_W]  = pre_q;
    ctl_rd[CTL_OSH]           = osh_q;
  end

  assign presc  = pre_q;
  assign ivl_rd = ivl_q;
  assign cnt_rd = cnt_q;
  assign en_o   = en_q;
  assign osh_o  = osh_q;
  assign rld_o  = rld_q;
  assign expire = fire;

endmodule

// File: rtl/evt_timer_top.sv
module evt_timer_top
  import evt_timer_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int DW       = 32,
  parameter int ADDR_W   = 8,
  parameter int PRE_W    = 3,
  parameter int SYNC_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);

  localparam int CH_IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CW    = 2 * DW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  fld_e                         fld;
  logic [CH_IW-1:0]             ch;
  logic                         wr;
  logic [NUM_CH-1:0]            ctl_we, ivl_lo_we, ivl_hi_we;
  logic [NUM_CH-1:0]            tick, expire;
  logic [NUM_CH-1:0]            en_v, osh_v, rld_v;
  logic [NUM_CH-1:0][PRE_W-1:0] presc;
  logic [NUM_CH-1:0][DW-1:0]    ctl_a;
  logic [NUM_CH-1:0][CW-1:0]    ivl_a, cnt_a;
  logic [NUM_CH-1:0]            ien_q, ien_n;
  logic [NUM_CH-1:0]            st_q,  st_n;
  logic [NUM_CH-1:0]            ist_clr;

  evt_timer_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_IW(CH_IW)) u_dec (
    .addr (bus_addr),
    .fld  (fld),
    .ch   (ch)
  );

  evt_timer_presc #(.NUM_CH(NUM_CH), .PRE_W(PRE_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .presc (presc),
    .tick  (tick)
  );

  assign wr = bus_sel && bus_we;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic sel_n;
    assign sel_n        = wr && (ch == CH_IW'(n));
    assign ctl_we[n]    = sel_n && (fld == FLD_CTL);
    assign ivl_lo_we[n] = sel_n && (fld == FLD_IVL_LO);
    assign ivl_hi_we[n] = sel_n && (fld == FLD_IVL_HI);

    evt_timer_chan #(.DW(DW), .PRE_W(PRE_W), .SYNC_LAT(SYNC_LAT)) u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .ctl_we    (ctl_we[n]),
      .ivl_lo_we (ivl_lo_we[n]),
      .ivl_hi_we (ivl_hi_we[n]),
      .wdata     (bus_wdata),
      .tick      (tick[n]),
      .ctl_rd    (ctl_a[n]),
      .presc     (presc[n]),
      .ivl_rd    (ivl_a[n]),
      .cnt_rd    (cnt_a[n]),
      .en_o      (en_v[n]),
      .osh_o     (osh_v[n]),
      .rld_o     (rld_v[n]),
      .expire    (expire[n])
    );
  end

  // mask and pending flags
  always_comb begin
    ien_n   = ien_q;
    if (wr && (fld == FLD_IEN)) ien_n = bus_wdata[NUM_CH-1:0];
    ist_clr = (wr && (fld == FLD_IST)) ? bus_wdata[NUM_CH-1:0] : '0;
    st_n    = (st_q & ~ist_clr) | expire;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ien_q <= '0;
      st_q  <= '0;
    end else begin
      ien_q <= ien_n;
      st_q  <= st_n;
    end
  end

  assign irq = |(st_q & ien_q);

  always_comb begin
    bus_rdata = '0;
    case (fld)
      FLD_IEN:    bus_rdata = DW'(ien_q);
      FLD_IST:    bus_rdata = DW'(st_q);
      FLD_CTL:    bus_rdata = ctl_a[ch];
      FLD_IVL_LO: bus_rdata = ivl_a[ch][DW-1:0];
      FLD_IVL_HI: bus_rdata = ivl_a[ch][CW-1:DW];
      FLD_CNT_LO: bus_rdata = cnt_a[ch][DW-1:0];
      FLD_CNT_HI: bus_rdata = cnt_a[ch][CW-1:DW];
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int NUM_CH   = 2,
  parameter int DW       = 32,
  parameter int ADDR_W   = 8,
  parameter int SYNC_LAT = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [DW-1:0]                bus_rdata,
  input logic                         irq,
  input logic                         wr_rld,
  input logic [NUM_CH-1:0]            ien_q,
  input logic [NUM_CH-1:0]            st_q,
  input logic [NUM_CH-1:0]            ist_clr,
  input logic [NUM_CH-1:0]            expire,
  input logic [NUM_CH-1:0]            ctl_we,
  input logic [NUM_CH-1:0]            tick,
  input logic [NUM_CH-1:0]            en_v,
  input logic [NUM_CH-1:0]            osh_v,
  input logic [NUM_CH-1:0]            rld_v,
  input logic [NUM_CH-1:0][2*DW-1:0]  cnt_a
);

  localparam int OFF_W = $clog2(SYNC_LAT + 2);

  // R2: no mask bit set, no interrupt
  assert_irq_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);

  // R10: offset 0x08 is never mapped
  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(8)) |-> (bus_rdata == '0));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    logic [OFF_W-1:0] off_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             off_cnt <= '0;
      else if (en_v[n])                       off_cnt <= '0;
      else if (off_cnt != OFF_W'(SYNC_LAT+1)) off_cnt <= off_cnt + OFF_W'(1);
    end

    // R11: a pending flag survives until a one is written to it
    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[n] && !ist_clr[n]) |=> st_q[n]);

    // R6: every expiry leaves its flag set
    assert_expire_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      expire[n] |=> st_q[n]);

    // R8: single-shot expiry drops the enable
    assert_oneshot_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[n] && osh_v[n] && !ctl_we[n]) |=> !en_v[n]);

    // R4: a load request is consumed by a tick
    assert_reload_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rld_v[n] && tick[n] && !(ctl_we[n] && wr_rld)) |=> !rld_v[n]);

    // R9: once the settling window has passed, the count holds
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_v[n] && (off_cnt >= OFF_W'(SYNC_LAT)) && !rld_v[n] && !ctl_we[n])
      |=> $stable(cnt_a[n]));
  end

endmodule

bind evt_timer_top evt_timer_chk #(
  .NUM_CH(NUM_CH), .DW(DW), .ADDR_W(ADDR_W), .SYNC_LAT(SYNC_LAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .wr_rld    (bus_wdata[1]),
  .ien_q     (ien_q),
  .st_q      (st_q),
  .ist_clr   (ist_clr),
  .expire    (expire),
  .ctl_we    (ctl_we),
  .tick      (tick),
  .en_v      (en_v),
  .osh_v     (osh_v),
  .rld_v     (rld_v),
  .cnt_a     (cnt_a)
);

// File: tb/sim_evt_timer_top.sv
module sim_evt_timer_top;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 0;

  evt_timer_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] a_ctl(int n);   return 8'(32*n + 16); endfunction
  function automatic logic [7:0] a_ivlo(int n);  return 8'(32*n + 20); endfunction
  function automatic logic [7:0] a_ivhi(int n);  return 8'(32*n + 24); endfunction
  function automatic logic [7:0] a_cnlo(int n);  return 8'(32*n + 28); endfunction
  function automatic logic [7:0] a_cnhi(int n);  return 8'(32*n + 32); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // caller is in the low phase of clk
  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_all();
    wr(a_ctl(0), 32'h0);
    wr(a_ctl(1), 32'h0);
    idle(6);
    wr(8'h04, 32'h3);
  endtask

  task automatic measure_gap(int b, output int gap);
    logic [31:0] d;
    int t1, t2, guard;
    bit got;
    got = 0; guard = 0; t1 = 0; t2 = 0;
    while (!got && guard < 3000) begin
      @(negedge clk);
      rd(8'h04, d);
      if (d[b]) begin t1 = cyc; got = 1; end
      guard++;
    end
    wr(8'h04, 32'(1 << b));
    got = 0; guard = 0;
    while (!got && guard < 3000) begin
      rd(8'h04, d);
      if (d[b]) begin t2 = cyc; got = 1; end
      else @(negedge clk);
      guard++;
    end
    gap = t2 - t1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d);    chk("R1 mask", d, 0);
    rd(8'h04, d);    chk("R1 status", d, 0);
    rd(a_ctl(0), d); chk("R1 ctl0", d, 0);
    rd(a_ivlo(1), d); chk("R1 ivl lo ch1", d, 0);
    rd(a_cnhi(0), d); chk("R1 cnt hi ch0", d, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(a_ivlo(1), 32'hA5A5_0001);
    wr(a_ivhi(1), 32'h0000_00C3);
    rd(a_ivlo(1), d); chk("R3 ivl lo ch1", d, 32'hA5A5_0001);
    rd(a_ivhi(1), d); chk("R3 ivl hi ch1", d, 32'h0000_00C3);
    rd(a_ivlo(0), d); chk("R3 ivl lo ch0 separate", d, 0);
  endtask

  task automatic t_reload();
    logic [31:0] d;
    wr(a_ivlo(0), 32'h0000_1234);
    wr(a_ivhi(0), 32'h0000_0005);
    wr(a_ctl(0), 32'h0000_0002);
    idle(3);
    rd(a_ctl(0), d);  chk("R4 load bit self-clears", d, 0);
    rd(a_cnlo(0), d); chk("R4 count lo loaded", d, 32'h1234);
    rd(a_cnhi(0), d); chk("R4 count hi loaded", d, 32'h5);
    idle(10);
    rd(a_cnlo(0), d); chk("R4 disabled count holds", d, 32'h1234);
  endtask

  task automatic t_freerun();
    logic [31:0] a, b;
    wr(a_ivlo(1), 32'hFFFF_FFFF);
    wr(a_ivhi(1), 32'h0);
    wr(a_ctl(1), 32'h0000_0003);
    idle(6);
    rd(a_ctl(1), a);  chk("R4 ctl readback running", a, 32'h1);
    rd(a_cnlo(1), a);
    idle(10);
    rd(a_cnlo(1), b);
    chk("R5 decrement over 10 clocks", a - b, 10);
    chk("R5 inverted value rises", (~b) - (~a), 10);
  endtask

  task automatic t_disable();
    logic [31:0] c, d;
    rd(a_cnlo(1), c);
    wr(a_ctl(1), 32'h0);
    idle(8);
    rd(a_cnlo(1), d);
    chk("R9 count after settling window", d, c - 3);
    idle(5);
    rd(a_cnlo(1), c);
    chk("R9 count holds", c, d);
  endtask

  task automatic t_period(int ivl, int p, string tag);
    int gap;
    stop_all();
    wr(a_ivlo(0), 32'(ivl));
    wr(a_ivhi(0), 32'h0);
    wr(a_ctl(0), 32'(3 | (p << 4)));
    measure_gap(0, gap);
    chk(tag, 32'(gap), 32'((ivl + 1) << p));
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    stop_all();
    wr(a_ivlo(0), 32'd5);
    wr(a_ivhi(0), 32'h0);
    wr(a_ctl(0), 32'h0000_0083);
    idle(40);
    rd(8'h04, d);     chk("R8 flag set", d & 32'h1, 1);
    rd(a_ctl(0), d);  chk("R8 enable cleared", d, 32'h80);
    rd(a_cnlo(0), d); chk("R8 count parked at 0", d, 0);
    wr(8'h04, 32'h1);
    idle(40);
    rd(8'h04, d);     chk("R8 no refire", d & 32'h1, 0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(8'h00, 32'h0);
    wr(a_ctl(0), 32'h0000_0083);
    idle(40);
    rd(8'h04, d);  chk("R11 masked flag readable", d & 32'h1, 1);
    chk("R11 masked flag no irq", 32'(irq), 0);
    wr(8'h00, 32'h1);
    chk("R2 irq with mask", 32'(irq), 1);
    wr(8'h04, 32'h2);
    rd(8'h04, d);  chk("R11 other bit leaves flag", d & 32'h1, 1);
    chk("R2 irq stays", 32'(irq), 1);
    wr(8'h04, 32'h1);
    rd(8'h04, d);  chk("R2 write one clears", d & 32'h1, 0);
    chk("R2 irq drops", 32'(irq), 0);
    rd(8'h00, d);  chk("R2 mask readback", d, 1);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h08, d);     chk("R10 read 0x08", d, 0);
    rd(8'h0C, d);     chk("R10 read 0x0C", d, 0);
    rd(8'h50, d);     chk("R10 read slot beyond channels", d, 0);
    rd(8'h00, d);     chk("R10 mask untouched", d, 1);
    rd(a_ctl(0), d);  chk("R10 ctl0 untouched", d, 32'h80);
    rd(a_ctl(1), d);  chk("R10 ctl1 untouched", d, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_map();
    t_reload();
    t_freerun();
    t_disable();
    t_period(3, 0, "R6 period I=3 p=0");
    t_period(4, 2, "R7 period I=4 p=2");
    t_period(1, 7, "R7 period I=1 p=7");
    t_oneshot();
    t_irq();
    t_unmapped();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule